// File: doc/BRIEF.md
# Compressed Half-Word Operation Expander

This block turns one half of a packed pair of 16-bit instructions into the fields the full-width decoder already knows. From a 4-bit compressed opcode, a destination register field, an operand register field and the raw half-word immediate bits, it returns a 5-bit full operation code, the destination and source register selects, a flag saying whether the source register is read, and a 9-bit immediate. The logic is purely combinational. A pipeline stage wraps it as needed. The other half of the pair is handled by another copy of the block.

The opcode map frees space in three ways:
- The old move with a 7-bit immediate is removed, because load-immediate covers its values.
- The former add-with-7-bit-immediate slot now carries that move.
- Load-immediate now owns both codes that have the two top opcode bits set, so it passes all 9 immediate bits unmodified.

Subtracting a register from itself plus a 3-bit immediate is of no practical use. That pattern is therefore recast as a left shift by 0 to 7. Two parameters pick the older layout instead, and in that layout the unused code is reported as invalid.

Top module: `cdx_half_expand`

## Requirements
- R1: The compressed opcode is split as `cop_i[3:1]` (3-bit operation) and `cop_i[0]` (form bit, 1 = register plus 3-bit immediate, 0 = 7-bit immediate). Operations 0, 1, 3, 4 and 5 map to full codes SUB 5'h00, AND 5'h01, CMP 5'h10, LW 5'h12 and SW 5'h13, and `valid_o` is 1.
- R2: With LDI_WIDE=1, any opcode with `cop_i[3:2]` = 2'b11 yields load-immediate 5'h18, with `imm_o` equal to `imm_i` bit for bit and `src_used_o` 0.
- R3: Operation 2 yields move 5'h0d for either value of the form bit, with `imm_o` the sign extension of `imm_i[6:0]` and `src_used_o` 0.
- R4: For operations 0, 1, 3, 4 and 5 with the form bit set, `src_o` equals `rb_i`, `src_used_o` is 1, and `imm_o` is the sign extension of `imm_i[2:0]`.
- R5: With SHL_TRICK=1, operation 0 with the form bit set and `rd_i` equal to `rb_i` yields shift-left 5'h06 with `imm_o` the zero extension of `imm_i[2:0]` (0 to 7) and `src_used_o` 0. When the fields differ, the result is a plain SUB.
- R6: For operations 0, 1 and 3 with the form bit clear, `imm_o` is the sign extension of `imm_i[6:0]` and `src_used_o` is 0.
- R7: For operations 4 and 5 with the form bit clear, `src_o` is the stack pointer register SP_REG (default 13), `src_used_o` is 1, and `imm_o` is the sign extension of `imm_i[6:0]`.
- R8: For every valid opcode, `dst_o` equals `rd_i`.
- R9: With LDI_WIDE=0, operation 6 yields load-immediate with `imm_o` the sign extension of `imm_i[7:0]`. Operation 7 is invalid: `valid_o` is 0, and `op_o`, `imm_o`, `src_o`, `dst_o` and `src_used_o` are all 0.
- R10: With SHL_TRICK=0, operation 0 with the form bit set and equal register fields stays SUB with a sign-extended 3-bit immediate and `src_used_o` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cop_i | input | 4 | Compressed opcode: operation in [3:1], form bit in [0] |
| rd_i | input | 4 | Destination register field |
| rb_i | input | 4 | Operand register field |
| imm_i | input | 9 | Raw half-word immediate bits |
| valid_o | output | 1 | Opcode maps to a defined operation |
| op_o | output | 5 | Full operation code |
| dst_o | output | 4 | Destination register select |
| src_o | output | 4 | Source register select |
| src_used_o | output | 1 | Source register is read |
| imm_o | output | 9 | Expanded immediate |

## Verification
The bench builds two copies side by side. The first uses the defaults (LDI_WIDE=1, SHL_TRICK=1, SP_REG=13), which brings the 9-bit load-immediate and the self-subtract shift within reach. The second uses LDI_WIDE=0 and SHL_TRICK=0, which exposes the invalid opcode, the 8-bit sign-extended load-immediate and the untouched self-subtract. Random half-words run through both copies. Directed vectors add the cases where a zero-extended shift of 7 must differ from a sign-extended -1, and the stack pointer substitution.

// File: rtl/cdx_pkg.sv
package cdx_pkg;
  localparam int unsigned OP_W  = 5;
  localparam int unsigned COP_W = 4;

  localparam logic [OP_W-1:0] FOP_SUB = 5'h00;
  localparam logic [OP_W-1:0] FOP_AND = 5'h01;
  localparam logic [OP_W-1:0] FOP_LSL = 5'h06;
  localparam logic [OP_W-1:0] FOP_MOV = 5'h0d;
  localparam logic [OP_W-1:0] FOP_CMP = 5'h10;
  localparam logic [OP_W-1:0] FOP_LW  = 5'h12;
  localparam logic [OP_W-1:0] FOP_SW  = 5'h13;
  localparam logic [OP_W-1:0] FOP_LDI = 5'h18;

  typedef enum logic [2:0] {
    IMM_ZERO, IMM_S3, IMM_Z3, IMM_S7, IMM_S8, IMM_RAW
  } imm_kind_e;

  typedef enum logic [1:0] {
    SRC_NONE, SRC_RB, SRC_SP
  } src_kind_e;

  typedef struct packed {
    logic            valid;
    logic [OP_W-1:0] fop;
    imm_kind_e       ikind;
    src_kind_e       skind;
  } map_t;
endpackage

// File: rtl/cdx_op_map.sv
module cdx_op_map
  import cdx_pkg::*;
#(
  parameter bit LDI_WIDE = 1'b1
) (
  input  logic [COP_W-1:0] cop_i,
  output map_t             map_o
);
  logic [2:0] op3;
  logic       form;
  map_t       base, hi;

  assign op3  = cop_i[3:1];
  assign form = cop_i[0];

  always_comb begin
    base = '{valid: 1'b1, fop: FOP_SUB, ikind: IMM_S7, skind: SRC_NONE};
    unique case (op3)
      3'd0: base.fop = FOP_SUB;
      3'd1: base.fop = FOP_AND;
      3'd2: base.fop = FOP_MOV;
      3'd3: base.fop = FOP_CMP;
      3'd4: base.fop = FOP_LW;
      3'd5: base.fop = FOP_SW;
      default: base.fop = FOP_LDI;
    endcase
    if (op3 != 3'd2) begin
      if (form) begin
        base.ikind = IMM_S3;
        base.skind = SRC_RB;
      end else if (op3 == 3'd4 || op3 == 3'd5) begin
        base.skind = SRC_SP;
      end
    end
  end

  generate
    if (LDI_WIDE) begin : g_ldi_wide
      always_comb begin
        hi = '{valid: 1'b1, fop: FOP_LDI, ikind: IMM_RAW, skind: SRC_NONE};
      end
    end else begin : g_ldi_narrow
      always_comb begin
        if (op3 == 3'd6)
          hi = '{valid: 1'b1, fop: FOP_LDI, ikind: IMM_S8, skind: SRC_NONE};
        else
          hi = '{valid: 1'b0, fop: '0, ikind: IMM_ZERO, skind: SRC_NONE};
      end
    end
  endgenerate

  assign map_o = (op3[2:1] == 2'b11) ? hi : base;
endmodule

// File: rtl/cdx_shl_detect.sv
module cdx_shl_detect
  import cdx_pkg::*;
#(
  parameter int unsigned REG_W     = 4,
  parameter bit          SHL_TRICK = 1'b1
) (
  input  logic [COP_W-1:0] cop_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic [REG_W-1:0] rb_i,
  output logic             hit_o
);
  generate
    if (SHL_TRICK) begin : g_on
      // SUB in reg+imm3 form with rd == rb
      assign hit_o = (cop_i == 4'b0001) && (rd_i == rb_i);
    end else begin : g_off
      logic unused_w;
      assign unused_w = ^{cop_i, rd_i, rb_i};
      assign hit_o    = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cdx_imm_sel.sv
module cdx_imm_sel
  import cdx_pkg::*;
#(
  parameter int unsigned IMM_W = 9
) (
  input  imm_kind_e        kind_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [IMM_W-1:0] imm_o
);
  localparam int unsigned SHORT_W = 3;
  localparam int unsigned MID_W   = IMM_W - 2;
  localparam int unsigned WIDE_W  = IMM_W - 1;

  logic [IMM_W-1:0] s3, z3, s7, s8;

  assign s3 = {{(IMM_W-SHORT_W){imm_i[SHORT_W-1]}}, imm_i[SHORT_W-1:0]};
  assign z3 = {{(IMM_W-SHORT_W){1'b0}}, imm_i[SHORT_W-1:0]};
  assign s7 = {{(IMM_W-MID_W){imm_i[MID_W-1]}}, imm_i[MID_W-1:0]};
  assign s8 = {{(IMM_W-WIDE_W){imm_i[WIDE_W-1]}}, imm_i[WIDE_W-1:0]};

  always_comb begin
    unique case (kind_i)
      IMM_S3:  imm_o = s3;
      IMM_Z3:  imm_o = z3;
      IMM_S7:  imm_o = s7;
      IMM_S8:  imm_o = s8;
      IMM_RAW: imm_o = imm_i;
      default: imm_o = '0;
    endcase
  end
endmodule

// File: rtl/cdx_half_expand.sv
module cdx_half_expand
  import cdx_pkg::*;
#(
  parameter int unsigned REG_W     = 4,
  parameter int unsigned IMM_W     = 9,
  parameter int unsigned SP_REG    = 13,
  parameter bit          LDI_WIDE  = 1'b1,
  parameter bit          SHL_TRICK = 1'b1
) (
  input  logic [COP_W-1:0] cop_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic [REG_W-1:0] rb_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             valid_o,
  output logic [OP_W-1:0]  op_o,
  output logic [REG_W-1:0] dst_o,
  output logic [REG_W-1:0] src_o,
  output logic             src_used_o,
  output logic [IMM_W-1:0] imm_o
);
  localparam logic [REG_W-1:0] SP_SEL = REG_W'(SP_REG);

  map_t map_w, fin;
  logic shl_hit;

  cdx_op_map #(.LDI_WIDE(LDI_WIDE)) u_map (
    .cop_i (cop_i),
    .map_o (map_w)
  );

  cdx_shl_detect #(.REG_W(REG_W), .SHL_TRICK(SHL_TRICK)) u_shl (
    .cop_i (cop_i),
    .rd_i  (rd_i),
    .rb_i  (rb_i),
    .hit_o (shl_hit)
  );

  always_comb begin
    fin = map_w;
    if (shl_hit) begin
      fin.fop   = FOP_LSL;
      fin.ikind = IMM_Z3;
      fin.skind = SRC_NONE;
    end
  end

  cdx_imm_sel #(.IMM_W(IMM_W)) u_imm (
    .kind_i (fin.ikind),
    .imm_i  (imm_i),
    .imm_o  (imm_o)
  );

  assign valid_o    = fin.valid;
  assign op_o       = fin.fop;
  assign dst_o      = fin.valid ? rd_i : '0;
  assign src_used_o = (fin.skind != SRC_NONE);

  always_comb begin
    unique case (fin.skind)
      SRC_RB:  src_o = rb_i;
      SRC_SP:  src_o = SP_SEL;
      default: src_o = '0;
    endcase
  end

  always_comb begin
    a_r2_ldi_raw: assert (!(LDI_WIDE && valid_o && cop_i[3:2] == 2'b11)
                          || (op_o == FOP_LDI && imm_o == imm_i && !src_used_o));
    a_r3_mov_no_src: assert (op_o != FOP_MOV || !src_used_o);
    a_r5_lsl_range: assert (op_o != FOP_LSL || (imm_o < IMM_W'(8) && !src_used_o));
    a_r7_sp_base: assert (!((op_o == FOP_LW || op_o == FOP_SW) && !cop_i[0])
                          || (src_o == SP_SEL && src_used_o));
    a_r9_invalid_quiet: assert (valid_o || (imm_o == '0 && !src_used_o && op_o == '0));
  end
endmodule

// File: tb/sim_cdx_half_expand.sv
module sim_cdx_half_expand;
  localparam int SP = 13;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] cop, rd, rb;
  logic [8:0] imm;
  logic       v0, v1, u0_used, u1_used;
  logic [4:0] op0, op1;
  logic [3:0] d0, d1, s0, s1;
  logic [8:0] i0, i1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cdx_half_expand u0 (
    .cop_i(cop), .rd_i(rd), .rb_i(rb), .imm_i(imm),
    .valid_o(v0), .op_o(op0), .dst_o(d0), .src_o(s0),
    .src_used_o(u0_used), .imm_o(i0)
  );

  cdx_half_expand #(.LDI_WIDE(1'b0), .SHL_TRICK(1'b0)) u1 (
    .cop_i(cop), .rd_i(rd), .rb_i(rb), .imm_i(imm),
    .valid_o(v1), .op_o(op1), .dst_o(d1), .src_o(s1),
    .src_used_o(u1_used), .imm_o(i1)
  );

  function automatic logic [8:0] sx(input logic [8:0] x, input int bits);
    logic [8:0] r;
    r = x & ((9'd1 << bits) - 9'd1);
    if (x[bits-1]) r = r | ~((9'd1 << bits) - 9'd1);
    return r;
  endfunction

  task automatic expect_of(input bit wide, input bit shl,
                           output logic ev, output logic [4:0] eop,
                           output logic [3:0] ed, output logic [3:0] es,
                           output logic eu, output logic [8:0] ei,
                           output string tag);
    int o;
    bit f;
    o = int'(cop[3:1]);
    f = cop[0];
    ev = 1; ed = rd; es = 0; eu = 0; ei = 0; eop = 0;
    if (o >= 6) begin
      if (wide) begin eop = 5'h18; ei = imm; tag = "R2"; end
      else if (o == 6) begin eop = 5'h18; ei = sx(imm, 8); tag = "R9"; end
      else begin ev = 0; ed = 0; tag = "R9"; end
    end else if (o == 2) begin
      eop = 5'h0d; ei = sx(imm, 7); tag = "R3";
    end else begin
      case (o)
        0: eop = 5'h00;
        1: eop = 5'h01;
        3: eop = 5'h10;
        4: eop = 5'h12;
        default: eop = 5'h13;
      endcase
      if (f) begin
        if (o == 0 && rd == rb && shl) begin
          eop = 5'h06; ei = {6'd0, imm[2:0]}; tag = "R5";
        end else begin
          es = rb; eu = 1; ei = sx(imm, 3);
          tag = (o == 0 && rd == rb) ? "R10" : "R4";
        end
      end else begin
        ei = sx(imm, 7);
        if (o >= 4) begin es = 4'(SP); eu = 1; tag = "R7"; end
        else tag = "R6";
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s cop=%h rd=%0d rb=%0d imm=%h act=%h exp=%h",
               tag, what, cop, rd, rb, imm, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [3:0] a,
                       input logic [3:0] b, input logic [8:0] m);
    logic ev; logic [4:0] eop; logic [3:0] ed, es; logic eu; logic [8:0] ei;
    string tag;
    @(posedge clk);
    cop = c; rd = a; rb = b; imm = m;
    @(negedge clk);
    expect_of(1'b1, 1'b1, ev, eop, ed, es, eu, ei, tag);
    chk((cop[3:1] < 6 && cop[3:1] != 2) ? "R1" : tag, "u0.valid", int'(v0), int'(ev));
    chk(tag, "u0.op", int'(op0), int'(eop));
    chk("R8", "u0.dst", int'(d0), int'(ed));
    chk(tag, "u0.src", int'(s0), int'(es));
    chk(tag, "u0.used", int'(u0_used), int'(eu));
    chk(tag, "u0.imm", int'(i0), int'(ei));
    expect_of(1'b0, 1'b0, ev, eop, ed, es, eu, ei, tag);
    chk(tag, "u1.valid", int'(v1), int'(ev));
    chk(tag, "u1.op", int'(op1), int'(eop));
    chk(tag, "u1.dst", int'(d1), int'(ed));
    chk(tag, "u1.src", int'(s1), int'(es));
    chk(tag, "u1.used", int'(u1_used), int'(eu));
    chk(tag, "u1.imm", int'(i1), int'(ei));
  endtask

  initial begin
    cop = 0; rd = 0; rb = 0; imm = 0;
    void'($urandom(32'd20240611));
    // directed corners
    apply(4'b0001, 4'd3, 4'd3, 9'h007); // R5 shift 7, not -1
    apply(4'b0001, 4'd3, 4'd4, 9'h007); // R4 plain SUB, sign-extended
    apply(4'b1110, 4'd2, 4'd9, 9'h1ff); // R2 raw / R9 invalid
    apply(4'b1100, 4'd2, 4'd9, 9'h080); // R2 raw / R9 8-bit sext
    apply(4'b1000, 4'd5, 4'd1, 9'h040); // R7 SP base
    apply(4'b1010, 4'd6, 4'd1, 9'h03f); // R7 store
    apply(4'b0101, 4'd7, 4'd7, 9'h041); // R3 form bit ignored
    apply(4'b0100, 4'd7, 4'd2, 9'h13f); // R3 positive
    apply(4'b0110, 4'd1, 4'd1, 9'h040); // R6 CMP imm7 negative
    apply(4'b0011, 4'd0, 4'd15, 9'h004); // R4 AND reg+imm3
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] a;
      a = 4'($urandom);
      apply(4'($urandom), a, ($urandom % 4 == 0) ? a : 4'($urandom), 9'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule